// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides what a small 32-bit in-order core does when an instruction faults, and what it does when a handler returns. The datapath reports breakpoints, system calls, data-bus faults (unmapped or misaligned access) and unsigned divides with their divisor. The block picks one request by a fixed priority. It computes the handler address from one of two base registers and issues the register-file write that records the faulting instruction's address. It also moves the interrupt-enable state into a shadow bit so the handler starts with interrupts off.

The block holds the control registers that take part in this sequence: the interrupt-enable register, the interrupt-pending register, the normal handler base and the debug handler base. A register-indirect branch through either link register brings the matching shadow enable back. All results are registered and appear one clock after the request.

Top module: `exc_ctrl`

## Requirements
- R1: A system call (ID 7), data-bus fault (ID 4) or zero-divisor divide (ID 5) pulses `exc_taken`, writes `cur_pc` into register 30, and sets `next_pc` to the normal base plus ID×32.
- R2: A breakpoint (ID 1) writes `cur_pc` into register 31 and sets `next_pc` to the debug base plus 32.
- R3: On normal entry the enable register becomes {0, old bit 0, 0}: old bit 0 moves to bit 1 and every other bit is cleared.
- R4: On breakpoint entry the enable register becomes {old bit 0, 0, 0}: old bit 0 moves to bit 2 and every other bit is cleared.
- R5: A return through register 30 sets the enable register to {0,0,old bit 1}. A return through register 31 sets it to {0,0,old bit 2}. A return through any other register leaves it unchanged.
- R6: A control write with selector 1 (pending) clears each pending bit whose write bit is 1 and leaves the other bits alone. An `irq_raise` bit sets its pending bit, and this set overrides a clear in the same cycle.
- R7: Selector 0 loads the enable register from `csr_wdata[2:0]`. Selector 2 loads the normal base and selector 3 loads the debug base, each from `csr_wdata` with bits 7:0 forced to 0.
- R8: A divide with a non-zero divisor writes `div_result` into `div_rd` and sets `next_pc` to `cur_pc`+4 with no exception. A zero divisor writes no destination and raises ID 5.
- R9: An unmapped fault and a misaligned fault both raise ID 4.
- R10: When several requests arrive in the same cycle, the lowest ID wins.
- R11: In a cycle that takes an exception, the same cycle's control write and return have no effect.
- R12: After reset all outputs and all four control registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 32 | Address of the instruction in execute |
| brk_req | input | 1 | Breakpoint request |
| scall_req | input | 1 | System call request |
| dbus_unmapped | input | 1 | Data access to an unmapped address |
| dbus_misalign | input | 1 | Misaligned data access |
| div_req | input | 1 | Unsigned divide or modulo in execute |
| div_divisor | input | 32 | Divisor operand |
| div_rd | input | 5 | Divide destination register |
| div_result | input | 32 | Divide result from the datapath |
| ret_valid | input | 1 | Register-indirect branch in execute |
| ret_reg | input | 5 | Source register of that branch |
| csr_we | input | 1 | Control register write |
| csr_sel | input | 2 | Write selector: 0 enable, 1 pending, 2 base, 3 debug base |
| csr_wdata | input | 32 | Write data |
| irq_raise | input | 8 | Interrupt lines that set pending bits |
| exc_taken | output | 1 | Exception accepted (one-cycle pulse) |
| exc_id | output | 3 | ID of the accepted exception |
| next_pc_vld | output | 1 | `next_pc` is valid |
| next_pc | output | 32 | Redirect address |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data |
| csr_ie | output | 3 | Interrupt-enable register |
| csr_ip | output | 8 | Interrupt-pending register |
| csr_eba | output | 32 | Normal handler base |
| csr_deba | output | 32 | Debug handler base |

## Verification
Every result is due exactly one rising edge after its request: the redirect, the link write, the exception ID and the new value of each control register. The bench therefore drives a request on a falling edge and checks every expected value on the next falling edge, halfway through the cycle after the capturing edge. Before the next stimulus it puts all inputs back to idle, so no result can leak into the following check. Expected enable, pending and base values come from a small model in the bench that is updated only from the requirement rules.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN      = 32;
    localparam int RA_W      = 5;
    localparam int NUM_EXC   = 8;
    localparam int ID_W      = $clog2(NUM_EXC);
    localparam int IE_W      = 3;
    localparam int VEC_SHIFT = 5;
    localparam int BASE_LSB  = 8;
    localparam int IRQ_W     = 8;

    localparam logic [RA_W-1:0] LINK_NORM = RA_W'(30);
    localparam logic [RA_W-1:0] LINK_DBG  = RA_W'(31);
    localparam logic [XLEN-1:0] BASE_MASK = ~((XLEN'(1) << BASE_LSB) - XLEN'(1));

    typedef enum logic [ID_W-1:0] {
        EXC_RESET = 3'd0,
        EXC_BREAK = 3'd1,
        EXC_IBUS  = 3'd2,
        EXC_WATCH = 3'd3,
        EXC_DBUS  = 3'd4,
        EXC_DIVZ  = 3'd5,
        EXC_IRQ   = 3'd6,
        EXC_SCALL = 3'd7
    } exc_id_e;

    typedef enum logic [1:0] {
        SEL_IE   = 2'd0,
        SEL_IP   = 2'd1,
        SEL_BASE = 2'd2,
        SEL_DBG  = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic            we;
        logic [RA_W-1:0] addr;
        logic [XLEN-1:0] data;
    } rf_wb_t;

    function automatic logic [IE_W-1:0] ie_enter(input logic [IE_W-1:0] ie, input logic dbg);
        return dbg ? {ie[0], 2'b00} : {1'b0, ie[0], 1'b0};
    endfunction

    function automatic logic [IE_W-1:0] ie_leave(input logic [IE_W-1:0] ie, input logic dbg);
        return {2'b00, dbg ? ie[2] : ie[1]};
    endfunction

    function automatic logic [XLEN-1:0] vector_of(input logic [XLEN-1:0] base,
                                                  input logic [ID_W-1:0] id);
        return base + (XLEN'(id) << VEC_SHIFT);
    endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
    parameter int N = exc_pkg::NUM_EXC,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] id
);

    always_comb begin
        hit = 1'b0;
        id  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                id  = W'(i);
            end
        end
    end

    assert_pick_valid_R10: assert property (@(posedge clk) disable iff (rst)
        hit |-> req[id]);

    assert_none_lower_R10: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((req & ((N'(1) << id) - N'(1))) == '0));

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> !hit);

endmodule

// File: rtl/exc_csr.sv
module exc_csr
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enter,
    input  logic             enter_dbg,
    input  logic             ret_act,
    input  logic             ret_dbg,
    input  logic             wr_en,
    input  csr_sel_e         wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [IRQ_W-1:0] irq_raise,
    output logic [IE_W-1:0]  ie,
    output logic [IRQ_W-1:0] ip,
    output logic [XLEN-1:0]  eba,
    output logic [XLEN-1:0]  deba
);

    logic [IRQ_W-1:0] ip_clr;

    always_comb begin
        ip_clr = '0;
        if (wr_en && wr_sel == SEL_IP)
            ip_clr = wr_data[IRQ_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie   <= '0;
            ip   <= '0;
            eba  <= '0;
            deba <= '0;
        end else begin
            if (enter)
                ie <= ie_enter(ie, enter_dbg);
            else if (ret_act)
                ie <= ie_leave(ie, ret_dbg);
            else if (wr_en && wr_sel == SEL_IE)
                ie <= wr_data[IE_W-1:0];

            ip <= (ip & ~ip_clr) | irq_raise;

            if (wr_en && wr_sel == SEL_BASE)
                eba <= wr_data & BASE_MASK;
            if (wr_en && wr_sel == SEL_DBG)
                deba <= wr_data & BASE_MASK;
        end
    end

    assert_ie_enter_norm_R3: assert property (@(posedge clk) disable iff (rst)
        enter && !enter_dbg |=> ie == {1'b0, $past(ie[0]), 1'b0});

    assert_ie_enter_dbg_R4: assert property (@(posedge clk) disable iff (rst)
        enter && enter_dbg |=> ie == {$past(ie[0]), 2'b00});

    assert_ie_return_R5: assert property (@(posedge clk) disable iff (rst)
        !enter && ret_act |=> ie[IE_W-1:1] == 2'b00);

    assert_ip_clear_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel == SEL_IP && irq_raise == '0
        |=> ip == ($past(ip) & ~$past(wr_data[IRQ_W-1:0])));

    assert_ip_raise_R6: assert property (@(posedge clk) disable iff (rst)
        irq_raise != '0 |=> (ip & $past(irq_raise)) == $past(irq_raise));

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             brk_req,
    input  logic             scall_req,
    input  logic             dbus_unmapped,
    input  logic             dbus_misalign,
    input  logic             div_req,
    input  logic [XLEN-1:0]  div_divisor,
    input  logic [RA_W-1:0]  div_rd,
    input  logic [XLEN-1:0]  div_result,
    input  logic             ret_valid,
    input  logic [RA_W-1:0]  ret_reg,
    input  logic             csr_we,
    input  logic [1:0]       csr_sel,
    input  logic [XLEN-1:0]  csr_wdata,
    input  logic [IRQ_W-1:0] irq_raise,
    output logic             exc_taken,
    output logic [ID_W-1:0]  exc_id,
    output logic             next_pc_vld,
    output logic [XLEN-1:0]  next_pc,
    output logic             rf_we,
    output logic [RA_W-1:0]  rf_waddr,
    output logic [XLEN-1:0]  rf_wdata,
    output logic [IE_W-1:0]  csr_ie,
    output logic [IRQ_W-1:0] csr_ip,
    output logic [XLEN-1:0]  csr_eba,
    output logic [XLEN-1:0]  csr_deba
);

    logic [NUM_EXC-1:0] req_vec;
    logic               hit;
    logic [ID_W-1:0]    id_sel;
    logic               is_dbg;
    logic               div_zero;
    logic               ret_act;
    logic               wr_ok;
    logic [XLEN-1:0]    vec_pc;
    rf_wb_t             wb_q;

    assign div_zero = div_req && (div_divisor == '0);

    always_comb begin
        req_vec            = '0;
        req_vec[EXC_BREAK] = brk_req;
        req_vec[EXC_DBUS]  = dbus_unmapped | dbus_misalign;
        req_vec[EXC_DIVZ]  = div_zero;
        req_vec[EXC_SCALL] = scall_req;
    end

    exc_prio #(.N(NUM_EXC), .W(ID_W)) u_prio (
        .clk (clk),
        .rst (rst),
        .req (req_vec),
        .hit (hit),
        .id  (id_sel)
    );

    assign is_dbg  = (id_sel == EXC_BREAK);
    assign vec_pc  = vector_of(is_dbg ? csr_deba : csr_eba, id_sel);
    assign ret_act = !hit && ret_valid && (ret_reg == LINK_NORM || ret_reg == LINK_DBG);
    assign wr_ok   = csr_we && !hit;

    exc_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .enter     (hit),
        .enter_dbg (is_dbg),
        .ret_act   (ret_act),
        .ret_dbg   (ret_reg == LINK_DBG),
        .wr_en     (wr_ok),
        .wr_sel    (csr_sel_e'(csr_sel)),
        .wr_data   (csr_wdata),
        .irq_raise (irq_raise),
        .ie        (csr_ie),
        .ip        (csr_ip),
        .eba       (csr_eba),
        .deba      (csr_deba)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_taken   <= 1'b0;
            exc_id      <= '0;
            next_pc_vld <= 1'b0;
            next_pc     <= '0;
            wb_q        <= '0;
        end else begin
            exc_taken <= hit;
            exc_id    <= hit ? id_sel : '0;
            if (hit) begin
                next_pc_vld <= 1'b1;
                next_pc     <= vec_pc;
                wb_q.we     <= 1'b1;
                wb_q.addr   <= is_dbg ? LINK_DBG : LINK_NORM;
                wb_q.data   <= cur_pc;
            end else if (div_req) begin
                next_pc_vld <= 1'b1;
                next_pc     <= cur_pc + XLEN'(4);
                wb_q.we     <= 1'b1;
                wb_q.addr   <= div_rd;
                wb_q.data   <= div_result;
            end else begin
                next_pc_vld <= 1'b0;
                next_pc     <= '0;
                wb_q        <= '0;
            end
        end
    end

    assign rf_we    = wb_q.we;
    assign rf_waddr = wb_q.addr;
    assign rf_wdata = wb_q.data;

    assert_link_norm_R1: assert property (@(posedge clk) disable iff (rst)
        exc_taken && exc_id != EXC_BREAK |-> rf_we && rf_waddr == LINK_NORM && next_pc_vld);

    assert_link_dbg_R2: assert property (@(posedge clk) disable iff (rst)
        exc_taken && exc_id == EXC_BREAK |-> rf_we && rf_waddr == LINK_DBG && next_pc_vld);

    assert_divz_trap_R8: assert property (@(posedge clk) disable iff (rst)
        div_zero |=> exc_taken);

    assert_dbus_id_R9: assert property (@(posedge clk) disable iff (rst)
        (dbus_unmapped || dbus_misalign) && !brk_req |=> exc_taken && exc_id == EXC_DBUS);

    assert_base_hold_R11: assert property (@(posedge clk) disable iff (rst)
        hit |=> $stable(csr_eba) && $stable(csr_deba));

endmodule

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb;
    import exc_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic [31:0]      cur_pc;
    logic             brk_req, scall_req, dbus_unmapped, dbus_misalign;
    logic             div_req;
    logic [31:0]      div_divisor, div_result;
    logic [4:0]       div_rd;
    logic             ret_valid;
    logic [4:0]       ret_reg;
    logic             csr_we;
    logic [1:0]       csr_sel;
    logic [31:0]      csr_wdata;
    logic [7:0]       irq_raise;
    logic             exc_taken, next_pc_vld, rf_we;
    logic [2:0]       exc_id;
    logic [31:0]      next_pc, rf_wdata, csr_eba, csr_deba;
    logic [4:0]       rf_waddr;
    logic [2:0]       csr_ie;
    logic [7:0]       csr_ip;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [2:0]  m_ie;
    logic [7:0]  m_ip;
    logic [31:0] m_eba, m_deba;

    always #5 clk = ~clk;

    exc_ctrl u_dut (
        .clk(clk), .rst(rst), .cur_pc(cur_pc),
        .brk_req(brk_req), .scall_req(scall_req),
        .dbus_unmapped(dbus_unmapped), .dbus_misalign(dbus_misalign),
        .div_req(div_req), .div_divisor(div_divisor), .div_rd(div_rd), .div_result(div_result),
        .ret_valid(ret_valid), .ret_reg(ret_reg),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata), .irq_raise(irq_raise),
        .exc_taken(exc_taken), .exc_id(exc_id), .next_pc_vld(next_pc_vld), .next_pc(next_pc),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .csr_ie(csr_ie), .csr_ip(csr_ip), .csr_eba(csr_eba), .csr_deba(csr_deba)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cur_pc = '0; brk_req = 0; scall_req = 0; dbus_unmapped = 0; dbus_misalign = 0;
        div_req = 0; div_divisor = '0; div_rd = '0; div_result = '0;
        ret_valid = 0; ret_reg = '0; csr_we = 0; csr_sel = '0; csr_wdata = '0; irq_raise = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1; idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 exc_taken", 32'(exc_taken), 0);
        check("R12 next_pc_vld", 32'(next_pc_vld), 0);
        check("R12 rf_we", 32'(rf_we), 0);
        check("R12 ie", 32'(csr_ie), 0);
        check("R12 ip", 32'(csr_ip), 0);
        check("R12 eba", csr_eba, 0);
        check("R12 deba", csr_deba, 0);
        m_ie = 0; m_ip = 0; m_eba = 0; m_deba = 0;
    endtask

    task automatic t_csr(input logic [1:0] sel, input logic [31:0] data, input logic [7:0] raise,
                         input string tag);
        csr_we = 1; csr_sel = sel; csr_wdata = data; irq_raise = raise;
        @(negedge clk);
        case (sel)
            2'd0: m_ie = data[2:0];
            2'd1: m_ip = m_ip & ~data[7:0];
            2'd2: m_eba = data & 32'hFFFF_FF00;
            default: m_deba = data & 32'hFFFF_FF00;
        endcase
        m_ip = m_ip | raise;
        check({tag, " ie"}, 32'(csr_ie), 32'(m_ie));
        check({tag, " ip"}, 32'(csr_ip), 32'(m_ip));
        check({tag, " eba"}, csr_eba, m_eba);
        check({tag, " deba"}, csr_deba, m_deba);
        idle();
    endtask

    task automatic t_exc(input logic b, input logic s, input logic um, input logic ma,
                         input logic dz, input logic [31:0] pc, input string tag);
        logic [2:0]  id;
        logic [31:0] npc;
        cur_pc = pc; brk_req = b; scall_req = s; dbus_unmapped = um; dbus_misalign = ma;
        if (dz) begin
            div_req = 1; div_divisor = 0; div_rd = 5'd9; div_result = 32'hDEAD_0000;
        end
        @(negedge clk);
        id  = b ? 3'd1 : (um || ma) ? 3'd4 : dz ? 3'd5 : 3'd7;
        npc = (b ? m_deba : m_eba) + (32'(id) << 5);
        m_ie = b ? {m_ie[0], 2'b00} : {1'b0, m_ie[0], 1'b0};
        check({tag, " taken"}, 32'(exc_taken), 1);
        check({tag, " id"}, 32'(exc_id), 32'(id));
        check({tag, " next_pc"}, next_pc, npc);
        check({tag, " rf_we"}, 32'(rf_we), 1);
        check({tag, " rf_waddr"}, 32'(rf_waddr), b ? 31 : 30);
        check({tag, " rf_wdata"}, rf_wdata, pc);
        check({tag, " ie"}, 32'(csr_ie), 32'(m_ie));
        idle();
    endtask

    task automatic t_ret(input logic [4:0] r, input string tag);
        ret_valid = 1; ret_reg = r;
        @(negedge clk);
        if (r == 5'd30) m_ie = {2'b00, m_ie[1]};
        else if (r == 5'd31) m_ie = {2'b00, m_ie[2]};
        check({tag, " ie"}, 32'(csr_ie), 32'(m_ie));
        check({tag, " no exc"}, 32'(exc_taken), 0);
        idle();
    endtask

    task automatic t_div_ok();
        cur_pc = 32'h300; div_req = 1; div_divisor = 3; div_rd = 5'd7; div_result = 32'd42;
        @(negedge clk);
        check("R8 no exc", 32'(exc_taken), 0);
        check("R8 rf_we", 32'(rf_we), 1);
        check("R8 rf_waddr", 32'(rf_waddr), 7);
        check("R8 rf_wdata", rf_wdata, 42);
        check("R8 next_pc", next_pc, 32'h304);
        idle();
    endtask

    task automatic t_suppress();
        cur_pc = 32'h500; scall_req = 1;
        csr_we = 1; csr_sel = 2'd2; csr_wdata = 32'hFFFF_FF00;
        ret_valid = 1; ret_reg = 5'd30;
        @(negedge clk);
        m_ie = {1'b0, m_ie[0], 1'b0};
        check("R11 eba kept", csr_eba, m_eba);
        check("R11 ie from entry", 32'(csr_ie), 32'(m_ie));
        check("R11 taken", 32'(exc_taken), 1);
        idle();
    endtask

    initial begin
        t_reset();
        t_csr(2'd2, 32'h1234_56FF, 8'h00, "R7 base");
        t_csr(2'd3, 32'hABCD_0077, 8'h00, "R7 dbase");
        t_csr(2'd0, 32'hFFFF_FFF9, 8'h00, "R7 ie");
        t_exc(0, 1, 0, 0, 0, 32'h100, "R1 R3 scall");
        t_ret(5'd30, "R5 ret30");
        t_ret(5'd5, "R5 ret other");
        t_exc(1, 0, 0, 0, 0, 32'h200, "R2 R4 brk");
        t_ret(5'd31, "R5 ret31");
        t_div_ok();
        t_exc(0, 0, 0, 0, 1, 32'h304, "R8 divz");
        t_ret(5'd30, "R5 ret30 b");
        t_exc(0, 0, 1, 0, 0, 32'h400, "R9 unmapped");
        t_exc(0, 0, 0, 1, 0, 32'h404, "R9 misalign");
        t_csr(2'd0, 32'h1, 8'h00, "R7 ie set");
        t_exc(1, 1, 0, 0, 1, 32'h600, "R10 brk wins");
        t_exc(0, 1, 1, 0, 1, 32'h604, "R10 dbus wins");
        t_exc(0, 1, 0, 0, 1, 32'h608, "R10 divz wins");
        t_suppress();
        t_csr(2'd1, 32'h0, 8'h0F, "R6 raise");
        t_csr(2'd1, 32'h5, 8'h00, "R6 w1c");
        t_csr(2'd1, 32'h3, 8'h01, "R6 raise wins");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule